// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block owns the program counter of a small 8-bit core during two single-word conditional branches: one taken while the overflow flag is clear and one taken while the zero flag is clear. Every instruction cycle has four phases that advance on a phase-enable tick. The unit captures the instruction word, forms a signed, word-scaled target, samples the tested flag and then updates the program counter.

A branch that is not taken finishes in one instruction cycle and moves the PC to the next word. A taken branch loads the target and then marks the following instruction cycle as a forced no-operation. During that idle cycle the PC holds and the instruction and flags are ignored. Any other instruction word is treated as an ordinary one-cycle instruction.

Top module: `brcu_top`

## Requirements
- R1: After a synchronous active-high reset, `pc` is 0, `nop_cycle` is 0 and `phase` is 0, which is the first phase.
- R2: `phase` holds on clocks without `ph_tick`. On each tick it advances 0→1→2→3 and wraps from 3 back to 0.
- R3: A word whose upper byte is 8'hE5 is taken exactly when `flag_ov` is 0.
- R4: A word whose upper byte is 8'hE1 is taken exactly when `flag_z` is 0.
- R5: A taken branch loads `pc` with (pc + 2 + 2·n) modulo 2^PC_W. Here n is the lower byte read as a two's-complement value from -128 to 127.
- R6: A branch that is not taken sets `pc` to pc + 2 at the phase-3 tick and leaves `nop_cycle` at 0.
- R7: After a taken branch, `nop_cycle` is 1 for the whole next instruction cycle. During that cycle `pc` holds, `instr` and the flags have no effect, and `nop_cycle` returns to 0 at its phase-3 tick.
- R8: `instr` is captured on the phase-0 tick. Later changes within the same cycle have no effect.
- R9: The tested flag is sampled on the phase-2 tick. Changes after that tick have no effect.
- R10: A word that matches neither upper byte advances `pc` by 2 in one cycle and never raises `nop_cycle`.
- R11: Bit 0 of `pc` is always 0. `pc` changes only on a phase-3 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_tick | input | 1 | Phase-enable tick |
| instr | input | 16 | Instruction word |
| flag_ov | input | 1 | Overflow status flag |
| flag_z | input | 1 | Zero status flag |
| pc | output | PC_W (21) | Program counter |
| nop_cycle | output | 1 | The current instruction cycle is a forced no-operation |
| phase | output | 2 | Current phase, 0 to 3 |

## Verification
The bench sweeps all 256 offsets for both opcodes under all four flag combinations. This exercises the extremes -128 and +127. Negative offsets taken from a PC near zero check that the sum wraps at 21 bits; a design that dropped sign extension or the doubling would land on a wrong, possibly odd, address.

Each taken branch is followed by an idle cycle fed with a branch that would be taken. A unit that did not suppress that cycle would jump a second time.

Directed cycles change the instruction after phase 0 and the flag after phase 2. A design that latched either input late would take the wrong path. Words that differ from an opcode in a single bit check that only exact matches branch.

// File: rtl/brcu_pkg.sv
package brcu_pkg;
    parameter int PC_W   = 21;
    parameter int WORD_W = 16;
    localparam int OFF_W = 8;
    localparam logic [7:0] OPC_NOV = 8'hE5;
    localparam logic [7:0] OPC_NZ  = 8'hE1;

    typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_t;

    typedef struct packed {
        logic             on_nov;
        logic             on_nz;
        logic [OFF_W-1:0] offset;
    } br_dec_t;

    function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base,
                                                   input logic [OFF_W-1:0] off);
        logic [PC_W-1:0] ext;
        ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        return base + PC_W'(2) + (ext << 1);
    endfunction
endpackage

// File: rtl/brcu_phase.sv
module brcu_phase
    import brcu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output phase_t ph
);
    always_ff @(posedge clk) begin
        if (rst)       ph <= PH_Q1;
        else if (tick) ph <= phase_t'(ph + 2'd1);
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(ph));
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst) (tick && ph == PH_Q4) |=> ph == PH_Q1);
endmodule

// File: rtl/brcu_decode.sv
module brcu_decode
    import brcu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output br_dec_t           dec
);
    always_comb begin
        dec.on_nov = (word[WORD_W-1 -: 8] == OPC_NOV);
        dec.on_nz  = (word[WORD_W-1 -: 8] == OPC_NZ);
        dec.offset = word[OFF_W-1:0];
    end

    a_r3_r4_excl: assert final (!(dec.on_nov && dec.on_nz));
endmodule

// File: rtl/brcu_top.sv
module brcu_top
    import brcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ph_tick,
    input  logic [WORD_W-1:0] instr,
    input  logic              flag_ov,
    input  logic              flag_z,
    output logic [PC_W-1:0]   pc,
    output logic              nop_cycle,
    output logic [1:0]        phase
);
    phase_t            ph;
    logic [WORD_W-1:0] ir_q;
    logic [PC_W-1:0]   tgt_q;
    logic              taken_q;
    br_dec_t           dec;

    brcu_phase u_phase (.clk(clk), .rst(rst), .tick(ph_tick), .ph(ph));
    brcu_decode u_dec (.word(ir_q), .dec(dec));

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q      <= '0;
            tgt_q     <= '0;
            taken_q   <= 1'b0;
            pc        <= '0;
            nop_cycle <= 1'b0;
        end else if (ph_tick) begin
            case (ph)
                PH_Q1: ir_q  <= instr;
                PH_Q2: tgt_q <= rel_target(pc, dec.offset);
                PH_Q3: taken_q <= !nop_cycle &&
                                  ((dec.on_nov && !flag_ov) || (dec.on_nz && !flag_z));
                PH_Q4: begin
                    if (nop_cycle) begin
                        nop_cycle <= 1'b0;
                    end else if (taken_q) begin
                        pc        <= tgt_q;
                        nop_cycle <= 1'b1;
                    end else begin
                        pc <= pc + PC_W'(2);
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase = ph;

    a_r11_pc_even: assert property (@(posedge clk) disable iff (rst) pc[0] == 1'b0);
    a_r11_pc_q4only: assert property (@(posedge clk) disable iff (rst)
        !(ph_tick && ph == PH_Q4) |=> $stable(pc));
    a_r7_nop_clears: assert property (@(posedge clk) disable iff (rst)
        (ph_tick && ph == PH_Q4 && nop_cycle) |=> (!nop_cycle && $stable(pc)));
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (ph_tick && ph == PH_Q4 && !nop_cycle && !taken_q) |=> (pc == $past(pc) + PC_W'(2) && !nop_cycle));
endmodule

// File: tb/tb_brcu_top.sv
module tb_brcu_top;
    localparam int PC_W = 21;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ph_tick = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic flag_ov = 1'b0;
    logic flag_z = 1'b0;
    logic [PC_W-1:0] pc;
    logic nop_cycle;
    logic [1:0] phase;

    int errors = 0;
    int checks = 0;
    logic [PC_W-1:0] pc_m = '0;

    brcu_top dut (.clk(clk), .rst(rst), .ph_tick(ph_tick), .instr(instr),
                  .flag_ov(flag_ov), .flag_z(flag_z), .pc(pc), .nop_cycle(nop_cycle), .phase(phase));

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) ph_tick = 1'b1;
        @(negedge clk) ph_tick = 1'b0;
    endtask

    function automatic logic [PC_W-1:0] exp_target(input logic [PC_W-1:0] p, input logic [7:0] n);
        int s;
        s = int'(p) + 2 + 2 * int'($signed(n));
        return PC_W'(s);
    endfunction

    function automatic bit exp_taken(input logic [15:0] w, input logic ov, input logic z);
        return (w[15:8] == 8'hE5 && !ov) || (w[15:8] == 8'hE1 && !z);
    endfunction

    // One full instruction cycle; optional late changes after Q1 / after Q3.
    task automatic run(input string req, input logic [15:0] w, input logic ov, input logic z,
                       input bit late_w, input bit late_f);
        bit t;
        t = exp_taken(w, ov, z);
        instr = w; flag_ov = ov; flag_z = z;
        tick();
        if (late_w) instr = ~w;                 // R8: ignored after Q1
        tick();
        tick();
        if (late_f) begin flag_ov = ~ov; flag_z = ~z; end  // R9: ignored after Q3 sample
        tick();
        pc_m = t ? exp_target(pc_m, w[7:0]) : pc_m + PC_W'(2);
        chk(req, 32'(pc), 32'(pc_m));
        chk(req, 32'(nop_cycle), 32'(t));
        chk("R11", 32'(pc[0]), 0);
        if (t) begin
            // R7: idle cycle, fed with a branch that would be taken
            instr = 16'hE500 | 16'(w[7:0] ^ 8'h5A); flag_ov = 1'b0; flag_z = 1'b0;
            tick(); tick(); tick();
            chk("R7", 32'(nop_cycle), 1);
            tick();
            chk("R7", 32'(pc), 32'(pc_m));
            chk("R7", 32'(nop_cycle), 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 32'(pc), 0);
        chk("R1", 32'(nop_cycle), 0);
        chk("R1", 32'(phase), 0);
        // R2: phase advance and hold
        tick();
        chk("R2", 32'(phase), 1);
        repeat (3) @(negedge clk);
        chk("R2", 32'(phase), 1);
        tick(); tick();
        chk("R2", 32'(phase), 3);
        tick();
        chk("R2", 32'(phase), 0);
        pc_m = pc_m + PC_W'(2);
        chk("R10", 32'(pc), 32'(pc_m));
        // R5 wrap: negative offset from a low PC
        run("R5", 16'hE180, 1'b1, 1'b0, 1'b0, 1'b0);
        // R8 / R9 late input changes
        run("R8", 16'hE510, 1'b0, 1'b1, 1'b1, 1'b0);
        run("R8", 16'h1AEF, 1'b0, 1'b0, 1'b1, 1'b0);
        run("R9", 16'hE120, 1'b0, 1'b0, 1'b0, 1'b1);
        run("R9", 16'hE520, 1'b1, 1'b0, 1'b0, 1'b1);
        // R10: near-miss encodings
        run("R10", 16'hE400, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R10", 16'hE3FF, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R10", 16'h6500, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R10", 16'hE000, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3 / R4 / R5 / R6 sweep over all offsets and flag pairs
        for (int n = 0; n < 256; n++) begin
            for (int f = 0; f < 4; f++) begin
                run(f[0] ? "R6" : "R3", 16'hE500 | 16'(n), f[0], f[1], 1'b0, 1'b0);
                run(f[1] ? "R6" : "R4", 16'hE100 | 16'(n), f[0], f[1], 1'b0, 1'b0);
            end
        end
        run("R5", 16'hE17F, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R5", 16'hE580, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule